// File: doc/BRIEF.md
# Distributed Shared-Bus Arbiter

This block decides which of up to six peer processors, or an external host, drives a shared external bus. Every peer carries its own copy of the arbiter. All copies see the same request lines, priority-mode select, lock line and host handshake, and each copy has a different agent number strapped on `my_id`. Because every copy runs the same next-state logic on the same inputs, all of them report the same owner on `master_id` in the same cycle, and only the copy whose number matches raises its local grant. No central arbitration unit is needed.

Agents are numbered 1 to 6, and request bit i belongs to agent i+1. A master that keeps its request asserted keeps the bus. When the master drops its request, the next owner is chosen by fixed priority or by rotating priority. Handing the bus from one processor to another takes one dead cycle. The current master can raise lock to make a read-modify-write sequence indivisible. The host requests the bus and is served ahead of any peer once the processor master is idle and not locked. The host then holds the bus until both its request and its chip select are low.

Top module: `mp_bus_arbiter`

## Requirements
- R1: After reset, `master_id` is 1, `host_grant` is 0, and only the copy with `my_id` = 1 asserts `my_grant`.
- R2: With `rotate_mode` = 0, when the current master's request bit is low and no host request is pending, the lowest-numbered requesting agent becomes the next master.
- R3: With `rotate_mode` = 1, the search for the next master starts at the agent numbered one above the releasing master and wraps from 6 to 1, so the releasing agent has the lowest priority. Under constant requests from all other agents, every agent is served equally often.
- R4: A processor-to-processor handover has exactly one cycle with `master_id` = 0 and `host_grant` = 0, and the new master appears in the next cycle.
- R5: While the current master's request bit is high, `master_id` does not change, whatever other agents or the host request.
- R6: While `lock` is high and a processor owns the bus, ownership does not change and `host_grant` stays 0, even if the master drops its request and the host requests.
- R7: `host_grant` rises only in the cycle after one in which a processor owned the bus with its request low and `lock` low while `host_req` was high. A pending host request wins over pending peer requests. While `host_grant` is 1, `master_id` is 0 and no `my_grant` is asserted.
- R8: `host_grant` stays 1 while `host_req` or `host_cs` is high. When both are low, the bus returns in the next cycle to the processor that owned it before the host, with no dead cycle.
- R9: When nobody requests, the current master keeps the bus, and its `my_grant` stays asserted.
- R10: All copies fed the same inputs report the same `master_id` every cycle. At most one copy asserts `my_grant`, and it is the copy whose `my_id` equals `master_id`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_id | input | 3 | Agent number of this copy, 1 to 6 |
| bus_req | input | 6 | Shared request lines, bit i is agent i+1 |
| rotate_mode | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| lock | input | 1 | Lock from the current master, holds ownership |
| host_req | input | 1 | Host bus request |
| host_cs | input | 1 | Host chip select, keeps the host on the bus while its access runs |
| my_grant | output | 1 | This copy's agent owns the bus |
| master_id | output | 3 | Current processor owner, 0 during handover or host tenure |
| host_grant | output | 1 | Host owns the bus |

## Verification
Two functions can fall in the same cycle. A master can drop its request while a host request and peer requests are both pending, and lock can be high in that same cycle. The bench sets up that cycle on purpose: it holds lock for several cycles with the host and a peer waiting, then releases lock. It checks that ownership stays frozen under lock and that the host, not the peer, takes the bus one cycle after the release. A behavioural model with integer state predicts every output of all six copies on every clock, so any difference in owner, dead cycle or host timing is reported along with the requirement in force at that moment.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PH_OWN  = 2'd0,
    PH_TURN = 2'd1,
    PH_HOST = 2'd2
  } arb_phase_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain[STAGES-1];

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_AGENTS = 6,
  localparam int IDW = $clog2(N_AGENTS + 1)
) (
  input  logic [N_AGENTS-1:0] req,
  input  logic [IDW-1:0]      last_id,
  input  logic                rotate,
  output logic [IDW-1:0]      win_id,
  output logic                win_valid
);

  // Scan starts at index 'base'. Fixed mode: base 0 (agent 1).
  // Rotating mode: base is the index just above the releasing agent.
  always_comb begin
    int base;
    int idx;
    win_id    = '0;
    win_valid = 1'b0;
    base      = rotate ? int'(last_id) : 0;
    if (base >= N_AGENTS) base = base - N_AGENTS;
    for (int k = 0; k < N_AGENTS; k++) begin
      idx = base + k;
      if (idx >= N_AGENTS) idx = idx - N_AGENTS;
      if (!win_valid && req[idx]) begin
        win_valid = 1'b1;
        win_id    = IDW'(idx + 1);
      end
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N_AGENTS = 6,
  localparam int IDW = $clog2(N_AGENTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req,
  input  logic                lock,
  input  logic                host_req,
  input  logic                host_cs,
  input  logic [IDW-1:0]      win_id,
  input  logic                win_valid,
  output arb_phase_e          phase,
  output logic [IDW-1:0]      owner
);

  arb_phase_e     phase_nx;
  logic [IDW-1:0] owner_nx;
  logic [IDW-1:0] pend, pend_nx;
  logic           owner_req;
  logic           state_en;

  always_comb begin
    owner_req = 1'b0;
    for (int i = 0; i < N_AGENTS; i++) begin
      if (owner == IDW'(i + 1)) owner_req = req[i];
    end
  end

  always_comb begin
    phase_nx = phase;
    owner_nx = owner;
    pend_nx  = pend;
    unique case (phase)
      PH_OWN: begin
        if (!lock && !owner_req) begin
          if (host_req) begin
            phase_nx = PH_HOST;
          end else if (win_valid) begin
            phase_nx = PH_TURN;
            pend_nx  = win_id;
          end
        end
      end
      PH_TURN: begin
        phase_nx = PH_OWN;
        owner_nx = pend;
      end
      PH_HOST: begin
        if (!host_req && !host_cs) phase_nx = PH_OWN;
      end
      default: phase_nx = PH_OWN;
    endcase
  end

  assign state_en = (phase_nx != phase) || (owner_nx != owner) || (pend_nx != pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OWN;
      owner <= IDW'(1);
      pend  <= IDW'(1);
    end else if (state_en) begin
      phase <= phase_nx;
      owner <= owner_nx;
      pend  <= pend_nx;
    end
  end

endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_AGENTS = 6,
  localparam int IDW = $clog2(N_AGENTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDW-1:0]      my_id,
  input  logic [N_AGENTS-1:0] bus_req,
  input  logic                rotate_mode,
  input  logic                lock,
  input  logic                host_req,
  input  logic                host_cs,
  output logic                my_grant,
  output logic [IDW-1:0]      master_id,
  output logic                host_grant
);

  logic           rst_n_int;
  arb_phase_e     phase;
  logic [IDW-1:0] owner;
  logic [IDW-1:0] win_id;
  logic           win_valid;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  arb_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .req       (bus_req),
    .last_id   (owner),
    .rotate    (rotate_mode),
    .win_id    (win_id),
    .win_valid (win_valid)
  );

  arb_ctrl #(.N_AGENTS(N_AGENTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req       (bus_req),
    .lock      (lock),
    .host_req  (host_req),
    .host_cs   (host_cs),
    .win_id    (win_id),
    .win_valid (win_valid),
    .phase     (phase),
    .owner     (owner)
  );

  assign master_id  = (phase == PH_OWN) ? owner : '0;
  assign host_grant = (phase == PH_HOST);
  assign my_grant   = (phase == PH_OWN) && (owner == my_id);

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_AGENTS = 6,
  localparam int IDW = $clog2(N_AGENTS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] bus_req,
  input logic                lock,
  input logic                host_req,
  input logic                host_cs,
  input logic [IDW-1:0]      master_id,
  input logic                host_grant
);

  logic owner_req;

  always_comb begin
    owner_req = 1'b0;
    for (int i = 0; i < N_AGENTS; i++) begin
      if (master_id == IDW'(i + 1)) owner_req = bus_req[i];
    end
  end

  p_dead_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_id == '0 && !host_grant) |=> (master_id != '0));

  p_keep_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_id != '0 && owner_req) |=> (master_id == $past(master_id)));

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_id != '0 && lock) |=> (master_id == $past(master_id) && !host_grant));

  p_host_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_grant) |-> $past(master_id != '0 && !owner_req && !lock && host_req));

  p_host_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant && (host_req || host_cs)) |=> host_grant);

  p_host_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> (master_id == '0));

endmodule

bind mp_bus_arbiter arb_checker #(.N_AGENTS(N_AGENTS)) u_arb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .lock       (lock),
  .host_req   (host_req),
  .host_cs    (host_cs),
  .master_id  (master_id),
  .host_grant (host_grant)
);

// File: tb/mp_bus_arbiter_test.sv
module mp_bus_arbiter_test;

  localparam int NA = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] req;
  logic       rot, lk, hreq, hcs;

  logic [6:1] gnt;
  logic [2:0] mid [6:1];
  logic [6:1] hg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  mp_bus_arbiter #(.N_AGENTS(NA)) uut (
    .clk(clk), .rst_n(rst_n), .my_id(3'd1), .bus_req(req),
    .rotate_mode(rot), .lock(lk), .host_req(hreq), .host_cs(hcs),
    .my_grant(gnt[1]), .master_id(mid[1]), .host_grant(hg[1])
  );

  for (genvar g = 2; g <= 6; g++) begin : g_peer
    mp_bus_arbiter #(.N_AGENTS(NA)) peer (
      .clk(clk), .rst_n(rst_n), .my_id(3'(g)), .bus_req(req),
      .rotate_mode(rot), .lock(lk), .host_req(hreq), .host_cs(hcs),
      .my_grant(gnt[g]), .master_id(mid[g]), .host_grant(hg[g])
    );
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 owner, 1 dead cycle, 2 host
  int m_ph, m_own, m_pend;
  int rst_cnt;

  function automatic int next_owner(input logic [5:0] r, input int last, input bit rotating);
    for (int k = 1; k <= 6; k++) begin
      int a;
      a = rotating ? ((last - 1 + k) % 6) + 1 : k;
      if (r[a-1]) return a;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_own = 1; m_pend = 1; rst_cnt = 0;
    end else if (rst_cnt < 2) begin
      rst_cnt = rst_cnt + 1;
    end else begin
      case (m_ph)
        0: if (!lk && !req[m_own-1]) begin
             if (hreq) m_ph = 2;
             else if (req != 6'd0) begin
               m_pend = next_owner(req, m_own, rot);
               m_ph   = 1;
             end
           end
        1: begin m_own = m_pend; m_ph = 0; end
        default: if (!hreq && !hcs) m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_m;
      exp_m = (m_ph == 0) ? m_own : 0;
      for (int a = 1; a <= 6; a++) begin
        check(int'(mid[a]) == exp_m, cur_tag, int'(mid[a]), exp_m);
        check(hg[a] == (m_ph == 2), cur_tag, int'(hg[a]), int'(m_ph == 2));
        check(gnt[a] == (m_ph == 0 && m_own == a), "R10", int'(gnt[a]), int'(m_ph == 0 && m_own == a));
      end
      check($countones(gnt) <= 1, "R10", $countones(gnt), 1);
    end
  end

  task automatic expect_m(input int exp, input bit exp_h, input string tag);
    check(int'(mid[1]) == exp, tag, int'(mid[1]), exp);
    check(hg[1] == exp_h, tag, int'(hg[1]), int'(exp_h));
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt [6:1];
    rst_n = 1'b0; req = '0; rot = 1'b0; lk = 1'b0; hreq = 1'b0; hcs = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    cur_tag = "R1";
    expect_m(1, 1'b0, "R1");
    check(gnt == 6'b000001, "R1", int'(gnt), 1);
    cur_tag = "R9";
    tick(3);
    expect_m(1, 1'b0, "R9");
    check(gnt[1] == 1'b1, "R9", int'(gnt[1]), 1);

    // fixed priority, agents 3 and 5 request
    cur_tag = "R2";
    req = 6'b010100;
    tick(1); expect_m(0, 1'b0, "R4");
    tick(1); expect_m(3, 1'b0, "R2");
    cur_tag = "R5";
    tick(2); expect_m(3, 1'b0, "R5");
    // 3 releases, 2 and 5 wait: fixed picks 2
    cur_tag = "R2";
    req = 6'b010010;
    tick(1); expect_m(0, 1'b0, "R4");
    tick(1); expect_m(2, 1'b0, "R2");

    // rotating priority
    cur_tag = "R3";
    rot = 1'b1;
    req = 6'b001001;               // agents 1 and 4, releasing 2 -> 4
    tick(2); expect_m(4, 1'b0, "R3");
    req = 6'b010001;               // agents 1 and 5, releasing 4 -> 5
    tick(2); expect_m(5, 1'b0, "R3");
    req = 6'b001001;               // agents 1 and 4, releasing 5 -> wrap to 1
    tick(2); expect_m(1, 1'b0, "R3");

    // lock while host and agent 2 wait
    cur_tag = "R6";
    lk = 1'b1; hreq = 1'b1; req = 6'b000010;
    tick(3); expect_m(1, 1'b0, "R6");
    cur_tag = "R7";
    lk = 1'b0;
    tick(1); expect_m(0, 1'b1, "R7");
    check(gnt == 6'b0, "R7", int'(gnt), 0);
    cur_tag = "R8";
    hreq = 1'b0; hcs = 1'b1;
    tick(2); expect_m(0, 1'b1, "R8");
    hcs = 1'b0;
    tick(1); expect_m(1, 1'b0, "R8");
    cur_tag = "R4";
    tick(1); expect_m(0, 1'b0, "R4");
    tick(1); expect_m(2, 1'b0, "R4");

    // host waits for a busy master
    cur_tag = "R7";
    hreq = 1'b1;
    tick(2); expect_m(2, 1'b0, "R7");
    req = 6'b0;
    tick(1); expect_m(0, 1'b1, "R7");
    hreq = 1'b0;
    tick(1); expect_m(2, 1'b0, "R8");

    // rotating fairness: all other agents always request
    cur_tag = "R3";
    for (int a = 1; a <= 6; a++) cnt[a] = 0;
    for (int r = 0; r < 12; r++) begin
      req = 6'h3f & ~(6'd1 << (int'(mid[1]) - 1));
      tick(2);
      if (mid[1] != 3'd0) cnt[int'(mid[1])]++;
    end
    for (int a = 1; a <= 6; a++) check(cnt[a] == 2, "R3", cnt[a], 2);

    cur_tag = "R9";
    req = 6'b0;
    tick(3);
    expect_m(2, 1'b0, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule